// File: doc/BRIEF.md
# Dual Serial Programming Port Arbiter

This block decides which of two serial programming ports may drive the chip's internal programming engine. One port is the standard port. The other is an alternate port, which a configuration bit can switch on or off. Each port has four inputs: a programming-entry request, an entry-type input (high-voltage or low-voltage), a serial clock and serial data in. Each port also has data-out and data-output-enable pins, which the engine drives back through the block.

Every port input passes through a two-flop synchronizer into the system clock domain. The first usable port to raise its entry request takes ownership, and keeps it until its request drops. While a port owns the session, the block sends that port's clock and data to a single engine-side clock and data pair. It forwards the engine's data-out and output enable only to the owning port's pins. The other port's entry, clock and data have no effect, and its data pin stays undriven. Voltage detection and the engine itself are outside this block.

Top module: `pgm_port_arbiter`

## Requirements
- R1: After reset the owner code is 00 (idle), `session_active` is 0, `session_hv` is 0, the engine-side clock and data are 0, both port output enables are 0, and the alternate-port enable bit is 1.
- R2: In idle, a rising synchronized entry on the standard port, with `std_pins_reassigned` low, sets the owner to 01 and sets `session_active` to 1. The owner register updates on the third rising clock edge after the input changes.
- R3: In idle, with the alternate-port enable bit set, a rising synchronized entry on the alternate port sets the owner to 10.
- R4: While the alternate-port enable bit is 0, alternate-port entry never starts a session and the alternate data-output enable stays 0. The standard port still works.
- R5: While `std_pins_reassigned` is 1, standard-port entry never starts a session.
- R6: While one port owns the session, the other port's entry, clock and data have no effect on the owner code, `eng_clk` or `eng_dat`. The owner never changes directly between 01 and 10.
- R7: If both ports' synchronized entries rise in the same cycle and both ports are usable, the standard port wins (owner 01).
- R8: The session ends and the owner returns to 00 when the owning port's entry drops. A port whose entry is still high at that moment cannot win until its entry falls and rises again.
- R9: `session_hv` takes the winning port's entry-type input at the moment it wins (1 = high-voltage, 0 = low-voltage). It holds that value for the whole session and is 0 in idle.
- R10: During a session, `eng_clk` and `eng_dat` equal the owning port's synchronized clock and data. In idle both are 0.
- R11: `eng_dat_oe` and `eng_dat_out` reach only the owning port's `*_dat_oe` and `*_dat_out` pins. The other port's pins, and both ports' pins in idle, stay 0.
- R12: Clearing the alternate-port enable bit during an alternate-port session ends that session (owner returns to 00).
- R13: A write pulse on `cfg_wr` loads `cfg_alt_en` into the alternate-port enable bit on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the alternate-port enable bit |
| cfg_alt_en | input | 1 | Value written into the alternate-port enable bit |
| std_pins_reassigned | input | 1 | High when firmware has given the standard pins another function |
| std_entry | input | 1 | Standard port programming-entry request |
| std_hv | input | 1 | Standard port entry type (1 = high-voltage) |
| std_clk | input | 1 | Standard port serial clock |
| std_dat_in | input | 1 | Standard port serial data in |
| std_dat_out | output | 1 | Standard port serial data out |
| std_dat_oe | output | 1 | Standard port data output enable |
| alt_entry | input | 1 | Alternate port programming-entry request |
| alt_hv | input | 1 | Alternate port entry type (1 = high-voltage) |
| alt_clk | input | 1 | Alternate port serial clock |
| alt_dat_in | input | 1 | Alternate port serial data in |
| alt_dat_out | output | 1 | Alternate port serial data out |
| alt_dat_oe | output | 1 | Alternate port data output enable |
| eng_dat_out | input | 1 | Data driven by the programming engine |
| eng_dat_oe | input | 1 | Output enable requested by the programming engine |
| eng_clk | output | 1 | Routed session clock to the engine |
| eng_dat | output | 1 | Routed session data to the engine |
| owner | output | 2 | Owner code: 00 idle, 01 standard, 10 alternate |
| session_active | output | 1 | High while a port owns the session |
| session_hv | output | 1 | Entry type of the current session |

## Verification
The bench drives the losing port with clock and data values that differ from the winner's. If the design leaked the losing port through the mux, `eng_clk` would show the wrong level. It raises both entries in the same cycle, where a design that got the priority backwards would hand the session to the alternate port. It releases a session while the other port's entry is still held high. A design that granted on level instead of on a rising edge would then start a new session at once. It also checks the three ways a port can be shut out: the configuration bit cleared before entry, the bit cleared during a session, and the standard pins reassigned. A broken design would leave a session running, or drive a data pin that should stay undriven.

// File: rtl/pgm_arb_pkg.sv
// Shared types for the dual programming port arbiter.
package pgm_arb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'b00,
        OWN_STD  = 2'b01,
        OWN_ALT  = 2'b10
    } owner_e;

    localparam int PORT_BITS = 4; // entry, type, clock, data per port
endpackage

// File: rtl/pgm_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes every bit is an independent slow-changing level.
module pgm_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    // Shift inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pgm_arb_ctrl.sv
// Ownership state machine: grants the session on a rising synchronized
// entry, standard port first on a tie, and releases when the owner's
// entry drops. Assumes all inputs are already synchronized.
module pgm_arb_ctrl
    import pgm_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   std_entry_s,
    input  logic   std_hv_s,
    input  logic   std_usable,
    input  logic   alt_entry_s,
    input  logic   alt_hv_s,
    input  logic   alt_usable,
    output owner_e owner,
    output logic   sess_hv
);
    logic std_prev, alt_prev;
    logic std_rise, alt_rise;

    assign std_rise = std_entry_s & ~std_prev;
    assign alt_rise = alt_entry_s & ~alt_prev;

    // Track previous entry levels and update the owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            std_prev <= 1'b0;
            alt_prev <= 1'b0;
            owner    <= OWN_NONE;
            sess_hv  <= 1'b0;
        end else begin
            std_prev <= std_entry_s;
            alt_prev <= alt_entry_s;
            case (owner)
                OWN_NONE: begin
                    if (std_rise && std_usable) begin
                        owner   <= OWN_STD;
                        sess_hv <= std_hv_s;
                    end else if (alt_rise && alt_usable) begin
                        owner   <= OWN_ALT;
                        sess_hv <= alt_hv_s;
                    end
                end
                OWN_STD: begin
                    if (!std_entry_s) begin
                        owner   <= OWN_NONE;
                        sess_hv <= 1'b0;
                    end
                end
                OWN_ALT: begin
                    if (!alt_entry_s || !alt_usable) begin
                        owner   <= OWN_NONE;
                        sess_hv <= 1'b0;
                    end
                end
                default: begin
                    owner   <= OWN_NONE;
                    sess_hv <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pgm_route.sv
// Combinational routing: owner's clock/data to the engine, engine
// data/enable back to the owner's pins only. Assumes a legal owner code.
module pgm_route
    import pgm_arb_pkg::*;
(
    input  owner_e owner,
    input  logic   std_clk_s,
    input  logic   std_dat_s,
    input  logic   alt_clk_s,
    input  logic   alt_dat_s,
    input  logic   eng_dat_out,
    input  logic   eng_dat_oe,
    output logic   eng_clk,
    output logic   eng_dat,
    output logic   std_dat_out,
    output logic   std_dat_oe,
    output logic   alt_dat_out,
    output logic   alt_dat_oe
);
    logic own_std, own_alt;

    assign own_std = (owner == OWN_STD);
    assign own_alt = (owner == OWN_ALT);

    // Select the session clock and data from the owning port.
    always_comb begin
        eng_clk = 1'b0;
        eng_dat = 1'b0;
        if (own_std) begin
            eng_clk = std_clk_s;
            eng_dat = std_dat_s;
        end else if (own_alt) begin
            eng_clk = alt_clk_s;
            eng_dat = alt_dat_s;
        end
    end

    // Forward engine drive only to the owning port.
    always_comb begin
        std_dat_oe  = own_std & eng_dat_oe;
        std_dat_out = own_std & eng_dat_out;
        alt_dat_oe  = own_alt & eng_dat_oe;
        alt_dat_out = own_alt & eng_dat_out;
    end
endmodule

// File: rtl/pgm_port_arbiter.sv
// Top of the dual programming port arbiter. Holds the alternate-port
// enable bit (set on reset), synchronizes both ports and ties together
// the ownership control and the routing. Assumes pins are split into
// separate in/out/enable signals by the pad ring.
module pgm_port_arbiter
    import pgm_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_alt_en,
    input  logic       std_pins_reassigned,
    input  logic       std_entry,
    input  logic       std_hv,
    input  logic       std_clk,
    input  logic       std_dat_in,
    output logic       std_dat_out,
    output logic       std_dat_oe,
    input  logic       alt_entry,
    input  logic       alt_hv,
    input  logic       alt_clk,
    input  logic       alt_dat_in,
    output logic       alt_dat_out,
    output logic       alt_dat_oe,
    input  logic       eng_dat_out,
    input  logic       eng_dat_oe,
    output logic       eng_clk,
    output logic       eng_dat,
    output logic [1:0] owner,
    output logic       session_active,
    output logic       session_hv
);
    localparam int BUNDLE = 2 * PORT_BITS;

    logic              alt_en_q;
    logic [BUNDLE-1:0] raw_bus, sync_bus;
    owner_e            owner_q;

    // Alternate-port enable bit; defaults to enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      alt_en_q <= 1'b1;
        else if (cfg_wr) alt_en_q <= cfg_alt_en;
    end

    assign raw_bus = {alt_dat_in, alt_clk, alt_hv, alt_entry,
                      std_dat_in, std_clk, std_hv, std_entry};

    pgm_sync #(.WIDTH(BUNDLE), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (sync_bus)
    );

    pgm_arb_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .std_entry_s (sync_bus[0]),
        .std_hv_s    (sync_bus[1]),
        .std_usable  (~std_pins_reassigned),
        .alt_entry_s (sync_bus[4]),
        .alt_hv_s    (sync_bus[5]),
        .alt_usable  (alt_en_q),
        .owner       (owner_q),
        .sess_hv     (session_hv)
    );

    pgm_route u_route (
        .owner       (owner_q),
        .std_clk_s   (sync_bus[2]),
        .std_dat_s   (sync_bus[3]),
        .alt_clk_s   (sync_bus[6]),
        .alt_dat_s   (sync_bus[7]),
        .eng_dat_out (eng_dat_out),
        .eng_dat_oe  (eng_dat_oe),
        .eng_clk     (eng_clk),
        .eng_dat     (eng_dat),
        .std_dat_out (std_dat_out),
        .std_dat_oe  (std_dat_oe),
        .alt_dat_out (alt_dat_out),
        .alt_dat_oe  (alt_dat_oe)
    );

    assign owner          = owner_q;
    assign session_active = (owner_q != OWN_NONE);
endmodule

// File: rtl/pgm_arb_chk.sv
// Property checker for the programming port arbiter, bound to the top.
module pgm_arb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       alt_en,
    input logic [1:0] owner,
    input logic       session_hv,
    input logic       eng_clk,
    input logic       eng_dat,
    input logic       std_dat_oe,
    input logic       alt_dat_oe
);
    // R6
    owner_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner != 2'b11);

    // R6
    no_std_to_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner == 2'b01 |=> owner != 2'b10);

    // R6
    no_alt_to_std_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner == 2'b10 |=> owner != 2'b01);

    // R11
    oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(std_dat_oe && alt_dat_oe));

    // R11
    idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner == 2'b00 |-> (!std_dat_oe && !alt_dat_oe));

    // R10
    idle_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner == 2'b00 |-> (!eng_clk && !eng_dat));

    // R12
    alt_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_en |=> owner != 2'b10);

    // R9
    hv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner != 2'b00 |=> (owner == 2'b00 || $stable(session_hv)));

    // R9
    idle_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner == 2'b00 |-> !session_hv);
endmodule

bind pgm_port_arbiter pgm_arb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alt_en     (alt_en_q),
    .owner      (owner),
    .session_hv (session_hv),
    .eng_clk    (eng_clk),
    .eng_dat    (eng_dat),
    .std_dat_oe (std_dat_oe),
    .alt_dat_oe (alt_dat_oe)
);

// File: tb/test_pgm_port_arbiter.sv
// Directed bench for the programming port arbiter.
module test_pgm_port_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_alt_en = 0, std_pins_reassigned = 0;
    logic std_entry = 0, std_hv = 0, std_clk = 0, std_dat_in = 0;
    logic alt_entry = 0, alt_hv = 0, alt_clk = 0, alt_dat_in = 0;
    logic eng_dat_out = 0, eng_dat_oe = 0;
    logic std_dat_out, std_dat_oe, alt_dat_out, alt_dat_oe;
    logic eng_clk, eng_dat, session_active, session_hv;
    logic [1:0] owner;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pgm_port_arbiter i_pgm_port_arbiter (.*);

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk);
        std_entry = 0; std_hv = 0; std_clk = 0; std_dat_in = 0;
        alt_entry = 0; alt_hv = 0; alt_clk = 0; alt_dat_in = 0;
        eng_dat_out = 0; eng_dat_oe = 0; std_pins_reassigned = 0;
        wait_n(5);
    endtask

    task automatic write_cfg(input logic v);
        @(negedge clk);
        cfg_wr = 1; cfg_alt_en = v;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic t_reset();
        check(owner, 2'b00, "R1 owner idle");
        check(session_active, 0, "R1 session inactive");
        check(session_hv, 0, "R1 hv low");
        check({eng_clk, eng_dat}, 2'b00, "R1 engine lines low");
        check({std_dat_oe, alt_dat_oe}, 2'b00, "R1 oe low");
    endtask

    task automatic t_std_session();
        @(negedge clk);
        std_entry = 1; std_hv = 1;
        wait_n(2);
        check(owner, 2'b00, "R2 owner not yet updated after two edges");
        wait_n(1);
        check(owner, 2'b01, "R2 standard owner on third edge");
        check(session_active, 1, "R2 session active");
        check(session_hv, 1, "R9 hv entry latched");
        std_clk = 1; std_dat_in = 1; alt_clk = 0; alt_dat_in = 0;
        wait_n(3);
        check({eng_clk, eng_dat}, 2'b11, "R10 routed std clk/dat");
        std_hv = 0;
        eng_dat_oe = 1; eng_dat_out = 1;
        wait_n(3);
        check(session_hv, 1, "R9 hv held in session");
        check({std_dat_oe, std_dat_out}, 2'b11, "R11 std drives");
        check({alt_dat_oe, alt_dat_out}, 2'b00, "R11 alt undriven");
        std_entry = 0;
        wait_n(4);
        check(owner, 2'b00, "R8 release on entry drop");
        check({eng_clk, eng_dat}, 2'b00, "R10 idle engine lines");
        check(std_dat_oe, 0, "R11 idle std oe");
        clear_all();
    endtask

    task automatic t_alt_first();
        @(negedge clk);
        alt_entry = 1; alt_hv = 0;
        wait_n(4);
        check(owner, 2'b10, "R3 alt wins with default cfg (R1)");
        check(session_hv, 0, "R9 low-voltage entry");
        std_entry = 1; std_clk = 1; std_dat_in = 1;
        alt_clk = 0; alt_dat_in = 0;
        eng_dat_oe = 1;
        wait_n(4);
        check(owner, 2'b10, "R6 std entry ignored");
        check({eng_clk, eng_dat}, 2'b00, "R6 std clk/dat ignored");
        check({alt_dat_oe, std_dat_oe}, 2'b10, "R11 oe to alt only");
        alt_entry = 0;
        wait_n(5);
        check(owner, 2'b00, "R8 held std entry does not win");
        std_entry = 0;
        wait_n(4);
        std_entry = 1;
        wait_n(4);
        check(owner, 2'b01, "R8 std wins after re-rise");
        clear_all();
    endtask

    task automatic t_simultaneous();
        @(negedge clk);
        std_entry = 1; alt_entry = 1; alt_hv = 1;
        wait_n(4);
        check(owner, 2'b01, "R7 standard wins tie");
        check(session_hv, 0, "R9 hv from winning std port");
        clear_all();
    endtask

    task automatic t_cfg_off();
        write_cfg(0);
        alt_entry = 1; eng_dat_oe = 1; eng_dat_out = 1;
        wait_n(5);
        check(owner, 2'b00, "R4 disabled alt cannot start");
        check(alt_dat_oe, 0, "R4 disabled alt undriven");
        std_entry = 1;
        wait_n(4);
        check(owner, 2'b01, "R4 std works with alt disabled");
        clear_all();
        write_cfg(1);
        alt_entry = 1;
        wait_n(4);
        check(owner, 2'b10, "R13 cfg write re-enables alt");
        clear_all();
    endtask

    task automatic t_cfg_drop_mid();
        @(negedge clk);
        alt_entry = 1;
        wait_n(4);
        check(owner, 2'b10, "R12 alt session started");
        write_cfg(0);
        wait_n(2);
        check(owner, 2'b00, "R12 session ends on cfg clear");
        write_cfg(1);
        clear_all();
    endtask

    task automatic t_reassigned();
        @(negedge clk);
        std_pins_reassigned = 1;
        std_entry = 1;
        wait_n(5);
        check(owner, 2'b00, "R5 reassigned std ignored");
        alt_entry = 1;
        wait_n(4);
        check(owner, 2'b10, "R5 alt still usable");
        clear_all();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1;
        wait_n(1);
        t_reset();
        t_std_session();
        t_alt_first();
        t_simultaneous();
        t_cfg_off();
        t_cfg_drop_mid();
        t_reassigned();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule